// File: doc/BRIEF.md
# Static Memory Bus Sequencer

This block turns single-word requests from an internal host port into read and write cycles on an external asynchronous parallel memory bus. The bus has six active-low chip selects. A request carries a write flag, a select index, an address and write data. It is accepted with a valid/ready handshake. Completion is reported on a one-cycle response strobe, with read data and an error flag.

Every select has its own 40-bit timing word and its own enable bit. The timing word sets the strobe widths, the read setup time, the write hold time and the turnaround recovery. It also sets the first-access latency for a new page and an optional address-latch (ADV) phase. The sequencer copies the timing word of the chosen select when it accepts a request. It remembers the last good access, so that it can decide whether recovery or page latency applies to the next one. A request to a disabled select, or to a select index above 5, produces no bus activity and finishes with the error flag set.

Top module: `smem_seq`

## Requirements
- R1: After reset, all chip selects and the OE, WE and ADV strobes are high, the data-out enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A request to a select index above 5, or to a select whose `cs_en` bit is 0, leaves every chip select high. It raises `rsp_valid` together with `rsp_err` in the cycle after acceptance.
- R3: The timing word for select i sits in bits `cfg_timing[40*i +: 40]`, laid out as: rd_wait [3:0], wr_wait [7:4], recovery [11:8], write hold [15:12], read delta [23:16], write delta [31:24], ADV-to-OE gap [33:32], read hold [37:34], ADV mode [38], address hold [39]. The word is copied when a request is accepted, so a change during an access has no effect until the next acceptance.
- R4: In a read, OE is low for rd_wait+1 cycles. `bus_din` is captured on the last OE-low cycle. `rsp_valid` is high for the one cycle after OE rises, with that captured value on `rsp_rdata`.
- R5: In a write, WE is low for wr_wait+1 cycles with data driven and `bus_doe` high. This is followed by write-hold cycles, during which the chip select stays low, `bus_doe` stays high and WE is high.
- R6: In a read with ADV mode off, the chip select is low for read-hold cycles before OE falls.
- R7: When the previous good access was a read, and the new access targets a different select or is a write, the block inserts recovery+1 cycles before the new access. The recovery count is taken from the previous access's word. During these cycles all chip selects are high and `bus_doe` is low. No recovery cycles are inserted in any other case.
- R8: A page is made of the address bits above the low 4. The first good access after reset, or an access whose select or page differs from the previous good access, inserts read-delta or write-delta cycles. During these cycles the chip select is low and no strobe is active.
- R9: With ADV mode on, ADV is low for one cycle with the chip select low. Address hold adds one further cycle. After that, a read waits ADV-to-OE-gap cycles before OE falls, and a write starts its WE strobe at once.
- R10: At most one chip select is low at any time, and `bus_doe` is never high while OE is low.
- R11: `req_ready` is low from acceptance until the response cycle has ended, and `rsp_valid` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 3 | Chip select index |
| req_addr | input | AW (16) | Word address |
| req_wdata | input | DW (16) | Write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | DW (16) | Read data |
| cs_en | input | 6 | Per-select enable |
| cfg_timing | input | 240 | Six 40-bit timing words |
| bus_cs_n | output | 6 | Active-low chip selects |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_we_n | output | 1 | Active-low write enable |
| bus_adv_n | output | 1 | Active-low address valid |
| bus_addr | output | AW (16) | Address bus |
| bus_dout | output | DW (16) | Data to memory |
| bus_doe | output | 1 | Data-out enable for the pad tristate |
| bus_din | input | DW (16) | Data from memory |

## Verification
The assertions check bus safety on every cycle. They check that at most one select is driven, that the data-out enable never overlaps OE, and that the bus is quiet during recovery. They also check that ADV is a single-cycle pulse, that a rejected request produces an error response with no select driven, and that handshake and response last one cycle each. Only the directed scenarios can show the exact cycle counts of each phase. This includes the choice to apply or skip recovery and page latency, which depends on access history. The scenarios also show that read data is taken on the last OE cycle and that a timing word changed during an access does not affect it.

// File: rtl/smem_pkg.sv
package smem_pkg;

  // Per-select timing word, least significant field last.
  typedef struct packed {
    logic       addr_hold;
    logic       adv_en;
    logic [3:0] rd_hold;
    logic [1:0] adv_oe;
    logic [7:0] wr_delta;
    logic [7:0] rd_delta;
    logic [3:0] wr_hold;
    logic [3:0] rec;
    logic [3:0] wr_wait;
    logic [3:0] rd_wait;
  } smem_tw_t;

  localparam int TW_BITS = $bits(smem_tw_t);
  localparam int LEN_W   = 9;

  // Phases in the order an access walks through them.
  typedef enum logic [3:0] {
    PH_IDLE, PH_RECOV, PH_LAT, PH_ADV, PH_AHOLD,
    PH_SETUP, PH_STROBE, PH_WHOLD, PH_RESP
  } smem_ph_t;

  typedef struct packed {
    logic       wr;
    logic       err;
    logic       need_rec;
    logic       new_page;
    logic [3:0] prev_rec;
    smem_tw_t   tw;
  } smem_job_t;

  // Number of cycles a phase lasts for a given job (0 = skipped).
  function automatic logic [LEN_W-1:0] ph_len(smem_ph_t ph, smem_job_t j);
    logic [LEN_W-1:0] n;
    n = '0;
    if (j.err) begin
      if (ph == PH_RESP) n = 1;
    end else begin
      case (ph)
        PH_RECOV:  n = j.need_rec ? LEN_W'(j.prev_rec) + 1 : '0;
        PH_LAT:    n = j.new_page ? LEN_W'(j.wr ? j.tw.wr_delta : j.tw.rd_delta) : '0;
        PH_ADV:    n = LEN_W'(j.tw.adv_en);
        PH_AHOLD:  n = LEN_W'(j.tw.adv_en & j.tw.addr_hold);
        PH_SETUP:  n = j.wr ? '0 : (j.tw.adv_en ? LEN_W'(j.tw.adv_oe) : LEN_W'(j.tw.rd_hold));
        PH_STROBE: n = LEN_W'(j.wr ? j.tw.wr_wait : j.tw.rd_wait) + 1;
        PH_WHOLD:  n = j.wr ? LEN_W'(j.tw.wr_hold) : '0;
        PH_RESP:   n = 1;
        default:   n = '0;
      endcase
    end
    return n;
  endfunction

  // First phase after 'ph' that has a non-zero length.
  function automatic smem_ph_t ph_after(smem_ph_t ph, smem_job_t j);
    smem_ph_t r;
    logic     found;
    r = PH_RESP;
    found = 1'b0;
    for (int k = int'(ph) + 1; k <= int'(PH_RESP); k++) begin
      if (!found && ph_len(smem_ph_t'(4'(k)), j) != '0) begin
        r = smem_ph_t'(4'(k));
        found = 1'b1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/smem_hist.sv
module smem_hist #(
  parameter int CSW = 3,
  parameter int PGW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd,
  input  logic           upd_rd,
  input  logic [3:0]     upd_rec,
  input  logic [CSW-1:0] q_cs,
  input  logic [PGW-1:0] q_page,
  input  logic           q_wr,
  output logic           need_rec,
  output logic           new_page,
  output logic [3:0]     prev_rec
);
  logic           h_valid;
  logic           h_rd;
  logic [CSW-1:0] h_cs;
  logic [PGW-1:0] h_page;
  logic [3:0]     h_rec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_valid <= 1'b0;
      h_rd    <= 1'b0;
      h_cs    <= '0;
      h_page  <= '0;
      h_rec   <= '0;
    end else if (upd) begin
      h_valid <= 1'b1;
      h_rd    <= upd_rd;
      h_cs    <= q_cs;
      h_page  <= q_page;
      h_rec   <= upd_rec;
    end
  end

  logic other_cs;
  assign other_cs = (q_cs != h_cs);
  assign need_rec = h_valid && h_rd && (other_cs || q_wr);
  assign new_page = !h_valid || other_cs || (q_page != h_page);
  assign prev_rec = h_rec;
endmodule

// File: rtl/smem_fsm.sv
module smem_fsm
  import smem_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int NCS = 6,
  parameter int CSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  smem_job_t      job_in,
  input  logic [CSW-1:0] cs_in,
  input  logic [AW-1:0]  addr_in,
  input  logic [DW-1:0]  wdata_in,
  output logic           idle,
  output logic           rsp_valid,
  output logic           rsp_err,
  output logic [DW-1:0]  rsp_rdata,
  output logic [NCS-1:0] bus_cs_n,
  output logic           bus_oe_n,
  output logic           bus_we_n,
  output logic           bus_adv_n,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_dout,
  output logic           bus_doe,
  input  logic [DW-1:0]  bus_din
);
  smem_ph_t         state;
  logic [LEN_W-1:0] cnt;
  smem_job_t        job;
  logic [CSW-1:0]   cs_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [DW-1:0]    rdata_q;

  smem_job_t        src_job;
  smem_ph_t         nxt_ph;
  logic [LEN_W-1:0] nxt_len;

  always_comb begin
    src_job = (state == PH_IDLE) ? job_in : job;
    nxt_ph  = ph_after(state, src_job);
    nxt_len = ph_len(nxt_ph, src_job);
  end

  logic phase_end;
  assign phase_end = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PH_IDLE;
      cnt     <= '0;
      job     <= '0;
      cs_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (state == PH_IDLE) begin
        if (start) begin
          job     <= job_in;
          cs_q    <= cs_in;
          addr_q  <= addr_in;
          wdata_q <= wdata_in;
          state   <= nxt_ph;
          cnt     <= nxt_len - 1'b1;
        end
      end else if (phase_end) begin
        if (state == PH_RESP) begin
          state <= PH_IDLE;
        end else begin
          state <= nxt_ph;
          cnt   <= nxt_len - 1'b1;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
      if (state == PH_STROBE && !job.wr && phase_end) rdata_q <= bus_din;
    end
  end

  // Named phase events.
  logic rec_phase, strobe_ph, whold_ph, drive_cs;
  assign rec_phase = (state == PH_RECOV);
  assign strobe_ph = (state == PH_STROBE);
  assign whold_ph  = (state == PH_WHOLD);
  assign drive_cs  = (state == PH_LAT) || (state == PH_ADV) || (state == PH_AHOLD) ||
                     (state == PH_SETUP) || strobe_ph || whold_ph;

  assign idle      = (state == PH_IDLE);
  assign bus_cs_n  = drive_cs ? ~(NCS'(1) << cs_q) : '1;
  assign bus_oe_n  = !(strobe_ph && !job.wr);
  assign bus_we_n  = !(strobe_ph && job.wr);
  assign bus_adv_n = !(state == PH_ADV);
  assign bus_doe   = job.wr && (strobe_ph || whold_ph);
  assign bus_addr  = addr_q;
  assign bus_dout  = wdata_q;
  assign rsp_valid = (state == PH_RESP);
  assign rsp_err   = job.err;
  assign rsp_rdata = rdata_q;

  // R10: bus safety
  p_one_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));
  p_no_contention_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> bus_oe_n);
  // R7: recovery leaves the bus idle
  p_recov_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_phase |-> (&bus_cs_n && !bus_doe));
  // R5: data driven only while a select is held
  p_doe_under_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> !(&bus_cs_n));
  // R9: ADV is a single-cycle pulse under an active select
  p_adv_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_adv_n |=> bus_adv_n);
  p_adv_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_adv_n |-> (!(&bus_cs_n) && bus_oe_n));
  // R11: response lasts one cycle
  p_rsp_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/smem_seq.sv
module smem_seq
  import smem_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int NCS       = 6,
  parameter int PAGE_BITS = 4,
  localparam int CSW      = $clog2(NCS),
  localparam int PGW      = AW - PAGE_BITS,
  localparam int NSLOT    = 1 << CSW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [CSW-1:0]     req_cs,
  input  logic [AW-1:0]      req_addr,
  input  logic [DW-1:0]      req_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [DW-1:0]      rsp_rdata,
  input  logic [NCS-1:0]     cs_en,
  input  logic [NCS*TW_BITS-1:0] cfg_timing,
  output logic [NCS-1:0]     bus_cs_n,
  output logic               bus_oe_n,
  output logic               bus_we_n,
  output logic               bus_adv_n,
  output logic [AW-1:0]      bus_addr,
  output logic [DW-1:0]      bus_dout,
  output logic               bus_doe,
  input  logic [DW-1:0]      bus_din
);
  smem_tw_t tw_arr [NCS];
  for (genvar g = 0; g < NCS; g++) begin : g_tw
    assign tw_arr[g] = smem_tw_t'(cfg_timing[g*TW_BITS +: TW_BITS]);
  end

  smem_tw_t sel_tw;
  always_comb begin
    sel_tw = '0;
    for (int i = 0; i < NCS; i++)
      if (req_cs == CSW'(i)) sel_tw = tw_arr[i];
  end

  logic [NSLOT-1:0] en_ext;
  logic             cs_ok, start, idle;
  assign en_ext = NSLOT'(cs_en);
  assign cs_ok  = en_ext[req_cs];
  assign start  = req_valid && idle;
  assign req_ready = idle;

  logic       need_rec, new_page;
  logic [3:0] prev_rec;

  smem_hist #(.CSW(CSW), .PGW(PGW)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (start && cs_ok),
    .upd_rd   (!req_write),
    .upd_rec  (sel_tw.rec),
    .q_cs     (req_cs),
    .q_page   (req_addr[AW-1:PAGE_BITS]),
    .q_wr     (req_write),
    .need_rec (need_rec),
    .new_page (new_page),
    .prev_rec (prev_rec)
  );

  smem_job_t job_in;
  always_comb begin
    job_in          = '0;
    job_in.wr       = req_write;
    job_in.err      = !cs_ok;
    job_in.need_rec = need_rec;
    job_in.new_page = new_page;
    job_in.prev_rec = prev_rec;
    job_in.tw       = sel_tw;
  end

  smem_fsm #(.AW(AW), .DW(DW), .NCS(NCS), .CSW(CSW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .job_in    (job_in),
    .cs_in     (req_cs),
    .addr_in   (req_addr),
    .wdata_in  (req_wdata),
    .idle      (idle),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .bus_cs_n  (bus_cs_n),
    .bus_oe_n  (bus_oe_n),
    .bus_we_n  (bus_we_n),
    .bus_adv_n (bus_adv_n),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .bus_doe   (bus_doe),
    .bus_din   (bus_din)
  );

  // R2: rejected request answers next cycle without touching the bus
  p_err_no_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cs_ok) |=> (&bus_cs_n && rsp_valid && rsp_err));
  // R11: acceptance drops ready
  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/smem_seq_tb.sv
module smem_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [2:0]  req_cs = '0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic [5:0]  cs_en = 6'b110111;
  logic [39:0] cfg_w [6];
  logic [239:0] cfg_timing;
  logic [5:0]  bus_cs_n;
  logic        bus_oe_n, bus_we_n, bus_adv_n, bus_doe;
  logic [15:0] bus_addr, bus_dout;
  logic [15:0] bus_din = '0;

  int checks = 0;
  int failures = 0;
  bit mut_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int i = 0; i < 6; i++) cfg_timing[i*40 +: 40] = cfg_w[i];

  smem_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cs_en(cs_en), .cfg_timing(cfg_timing), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_adv_n(bus_adv_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din)
  );

  function automatic logic [39:0] mk_cfg(int rdw, int wrw, int rec, int wh, int rdd,
                                         int wrd, int aoe, int rh, int adv, int ah);
    return (40'(ah) << 39) | (40'(adv) << 38) | (40'(rh) << 34) | (40'(aoe) << 32) |
           (40'(wrd) << 24) | (40'(rdd) << 16) | (40'(wh) << 12) | (40'(rec) << 8) |
           (40'(wrw) << 4) | 40'(rdw);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One access: drive, trace the bus per cycle, compare phase counts.
  task automatic do_access(input bit wr, input logic [2:0] cs, input logic [15:0] addr,
                           input logic [15:0] data, input int e_idle, input int e_pre,
                           input int e_adv, input int e_str, input int e_post,
                           input bit e_err, input string tag);
    int n_idle = 0, n_pre = 0, n_adv = 0, n_str = 0, n_post = 0, sc = 0;
    bit seen_cs = 0, seen_str = 0, done = 0, bad_bus = 0, bad_rdy = 0, bad_w = 0, cs_any;
    logic [15:0] pat;
    logic got_err;
    logic [15:0] got_rd;
    pat = addr ^ 16'h5A00;
    got_err = 1'b0;
    got_rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cs = cs; req_addr = addr; req_wdata = data;
    bus_din = '0;
    @(posedge clk);
    for (int n = 0; n < 700 && !done; n++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (mut_on && n == 0) cfg_w[0][3:0] = 4'd9;
      if (req_ready) bad_rdy = 1;
      if (bus_doe && !bus_oe_n) bad_bus = 1;
      if (rsp_valid) begin
        done = 1; got_err = rsp_err; got_rd = rsp_rdata;
        if (bus_cs_n != 6'h3F) bad_bus = 1;
      end else begin
        cs_any = (bus_cs_n != 6'h3F);
        if (cs_any && bus_cs_n != ~(6'b1 << cs)) bad_bus = 1;
        if (!cs_any) begin
          if (seen_cs || bus_doe) bad_bus = 1;
          n_idle++;
        end else begin
          seen_cs = 1;
          if (!bus_oe_n || !bus_we_n) begin
            n_str++; seen_str = 1;
            if (wr && (!bus_doe || bus_dout != data || bus_addr != addr)) bad_w = 1;
            if (!bus_oe_n) begin sc++; bus_din = pat + 16'(sc); end
          end else if (!seen_str) begin
            n_pre++;
            if (!bus_adv_n) n_adv++;
            if (bus_doe) bad_bus = 1;
          end else begin
            n_post++;
            if (wr && (!bus_doe || bus_dout != data)) bad_w = 1;
          end
        end
      end
    end
    chk(done, "R11", {tag, " response seen"}, int'(done), 1);
    chk(n_idle == e_idle, "R7", {tag, " recovery cycles"}, n_idle, e_idle);
    chk(n_pre == e_pre, "R8", {tag, " cycles before strobe (R6 R9 latency)"}, n_pre, e_pre);
    chk(n_adv == e_adv, "R9", {tag, " ADV cycles"}, n_adv, e_adv);
    chk(n_str == e_str, wr ? "R5" : "R4", {tag, " strobe cycles"}, n_str, e_str);
    chk(n_post == e_post, "R5", {tag, " write hold cycles"}, n_post, e_post);
    chk(got_err == e_err, "R2", {tag, " error flag"}, int'(got_err), int'(e_err));
    chk(!bad_bus, "R10", {tag, " bus select/contention rules"}, int'(bad_bus), 0);
    chk(!bad_rdy, "R11", {tag, " ready low while busy"}, int'(bad_rdy), 0);
    if (wr) chk(!bad_w, "R5", {tag, " write data driven"}, int'(bad_w), 0);
    if (!wr && !e_err) chk(got_rd == pat + 16'(e_str), "R4", {tag, " read data"},
                           int'(got_rd), int'(pat + 16'(e_str)));
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R11", {tag, " response single cycle"},
        int'({rsp_valid, req_ready}), 1);
  endtask

  task automatic t_reset();
    chk(bus_cs_n == 6'h3F && bus_oe_n && bus_we_n && bus_adv_n && !bus_doe, "R1",
        "bus idle after reset", int'({bus_cs_n, bus_oe_n, bus_we_n, bus_adv_n, bus_doe}), 'h3FE);
    chk(req_ready && !rsp_valid, "R1", "handshake after reset", int'({req_ready, rsp_valid}), 2);
  endtask

  task automatic t_page_reads();
    do_access(0, 3'd0, 16'h0010, 16'h0, 0, 5, 0, 3, 0, 0, "R8 first read");
    do_access(0, 3'd0, 16'h0012, 16'h0, 0, 2, 0, 3, 0, 0, "R6 same page read");
  endtask

  task automatic t_writes();
    do_access(1, 3'd0, 16'h0013, 16'hBEEF, 2, 0, 0, 2, 2, 0, "R7 read-to-write");
    do_access(1, 3'd0, 16'h0025, 16'h1234, 0, 2, 0, 2, 2, 0, "R8 write new page");
  endtask

  task automatic t_rejects();
    do_access(0, 3'd3, 16'h0100, 16'h0, 0, 0, 0, 0, 0, 1, "R2 disabled select");
    do_access(1, 3'd7, 16'h0100, 16'hAAAA, 0, 0, 0, 0, 0, 1, "R2 select 7");
  endtask

  task automatic t_adv_and_recovery();
    do_access(0, 3'd1, 16'h0040, 16'h0, 0, 4, 1, 1, 0, 0, "R9 adv read");
    do_access(0, 3'd2, 16'h0100, 16'h0, 4, 1, 0, 5, 0, 0, "R7 other-select read");
    do_access(1, 3'd1, 16'h0041, 16'h0F0F, 1, 3, 1, 4, 0, 0, "R9 adv write");
  endtask

  task automatic t_cfg_sampling();
    mut_on = 1'b1;
    do_access(0, 3'd0, 16'h0025, 16'h0, 0, 5, 0, 3, 0, 0, "R3 word held");
    mut_on = 1'b0;
    do_access(0, 3'd0, 16'h0026, 16'h0, 0, 2, 0, 10, 0, 0, "R3 new word used");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    cfg_w[0] = mk_cfg(2, 1, 1, 2, 3, 2, 0, 2, 0, 0);
    cfg_w[1] = mk_cfg(0, 3, 3, 0, 0, 1, 2, 0, 1, 1);
    cfg_w[2] = mk_cfg(4, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    cfg_w[3] = mk_cfg(1, 1, 1, 1, 1, 1, 0, 1, 0, 0);
    cfg_w[4] = '0;
    cfg_w[5] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_page_reads();
    t_writes();
    t_rejects();
    t_adv_and_recovery();
    t_cfg_sampling();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule